// File: doc/BRIEF.md
# Mesh Wraparound Bit Substitution

This block sits between the word rotator and the processing elements on each chip of a lockstep mesh that together hold one large lattice, split into equal sectors. A rotated 64-bit word carries bits that, after the local periodic shift, have wrapped around to the wrong edge of the sector. For each spatial direction, a 64-bit wrap mask from the addressing logic marks those bits. The block sends the marked bits out on that direction's link. It then puts the bits arriving on the same wire positions from the neighbouring chip in their place.

The three directions are handled in turn, x first, then y, then z, and each one is a registered pipeline stage. The word that y works on therefore already holds the bits substituted in x, and the word that z works on holds the bits substituted in x and y. This is how bits that cross a corner of the sector reach the right chip. Every chip runs the same schedule in the same cycles. The outgoing bits of a stage and the incoming bits that replace them belong to the same clock cycle. A valid flag goes with each word, and nothing can stall the pipe.

Top module: `mesh_wrap_subst`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three clock cycles earlier, with no stall or bubble added.
- R2: In the cycle a valid word is presented, `tx_x` equals `in_word & mask_x`. Bit positions whose mask bit is 0 read as 0.
- R3: A bit whose mask bit is 1 in a direction is replaced by the same bit position of that direction's incoming word. `rx_x` is sampled in the cycle the word is presented, `rx_y` one cycle later and `rx_z` two cycles later.
- R4: Directions apply in the order x, y, z. `tx_y` (one cycle after input) carries the word after x substitution, ANDed with that word's `mask_y`. `tx_z` (two cycles after input) carries the word after x and y substitution, ANDed with its `mask_z`.
- R5: A bit position that is 0 in all three masks reaches `out_word` unchanged. An all-zero mask makes its stage pass the word through, and that stage's incoming link has no effect.
- R6: A cycle with no valid word at a stage drives that stage's `tx_*` to all zeros. A non-valid input produces `out_valid` = 0 and `out_word` = 0 three cycles later, whatever the data, mask and link inputs were.
- R7: Synchronous active-high `rst` clears the pipeline. During reset and in the first cycles after it, `out_valid`, `out_word` and all `tx_*` read 0 until valid words arrive.
- R8: A new word can be accepted on every cycle. Back-to-back words do not disturb each other's masks or link data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all chips in lockstep |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A rotated word is presented this cycle |
| in_word | input | 64 | Rotated word from the shifter |
| mask_x | input | 64 | Wrapped-bit mask for the x direction |
| mask_y | input | 64 | Wrapped-bit mask for the y direction |
| mask_z | input | 64 | Wrapped-bit mask for the z direction |
| rx_x | input | 64 | Incoming bits from the x neighbour |
| rx_y | input | 64 | Incoming bits from the y neighbour |
| rx_z | input | 64 | Incoming bits from the z neighbour |
| tx_x | output | 64 | Outgoing wrapped bits to the x neighbour |
| tx_y | output | 64 | Outgoing wrapped bits to the y neighbour |
| tx_z | output | 64 | Outgoing wrapped bits to the z neighbour |
| out_valid | output | 1 | Corrected word available |
| out_word | output | 64 | Corrected word to the processor |

## Verification
The bound checker tests the following on every cycle:
- the three-cycle valid latency;
- that outgoing link bits never appear outside their mask;
- that idle stages and idle outputs are zero;
- that unmasked bits of the output match the input word from three cycles earlier;
- that z-masked output bits match the z link from one cycle earlier.

Only the bench's scenarios can show the ordering between directions. This covers overlapping x and y masks, where a bit substituted in x must be the one sent out in y. The bench also shows that back-to-back words keep their own masks, and it covers the effect of a reset that lands in the middle of a run of words.

// File: rtl/lattice_subst_pkg.sv
package lattice_subst_pkg;

    localparam int WORD_W   = 64;
    localparam int NUM_DIRS = 3;

    typedef logic [WORD_W-1:0] word_t;

    // Spatial directions in the order they are processed.
    typedef enum logic [1:0] {
        DIR_X = 2'd0,
        DIR_Y = 2'd1,
        DIR_Z = 2'd2
    } dir_e;

    // One word travelling down the substitution pipe, with its masks.
    typedef struct packed {
        logic                       valid;
        word_t                      data;
        logic [NUM_DIRS-1:0][WORD_W-1:0] mask;
    } beat_t;

    // Keep local bits where sel is 0, take neighbour bits where sel is 1.
    function automatic word_t merge_bits(word_t local_w, word_t nbr_w, word_t sel);
        return (local_w & ~sel) | (nbr_w & sel);
    endfunction

endpackage

// File: rtl/wrap_link_gate.sv
module wrap_link_gate
    import lattice_subst_pkg::*;
(
    input  logic  valid,
    input  word_t data,
    input  word_t sel,
    output word_t link_bits
);
    // Only wrapped bits of a valid word leave the chip; an idle slot sends zeros.
    always_comb begin
        if (valid) link_bits = data & sel;
        else       link_bits = '0;
    end
endmodule

// File: rtl/wrap_stage.sv
module wrap_stage
    import lattice_subst_pkg::*;
#(
    parameter int DIR_IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    input  word_t rx_bits,
    output word_t tx_bits,
    output beat_t out_beat
);
    word_t sel;
    word_t merged;

    assign sel    = in_beat.mask[DIR_IDX];
    assign merged = merge_bits(in_beat.data, rx_bits, sel);

    wrap_link_gate u_gate (
        .valid     (in_beat.valid),
        .data      (in_beat.data),
        .sel       (sel),
        .link_bits (tx_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_beat <= '0;
        end else if (in_beat.valid) begin
            out_beat.valid <= 1'b1;
            out_beat.data  <= merged;
            out_beat.mask  <= in_beat.mask;
        end else begin
            out_beat <= '0;
        end
    end
endmodule

// File: rtl/mesh_wrap_subst.sv
module mesh_wrap_subst
    import lattice_subst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_word,
    input  logic [63:0] mask_x,
    input  logic [63:0] mask_y,
    input  logic [63:0] mask_z,
    input  logic [63:0] rx_x,
    input  logic [63:0] rx_y,
    input  logic [63:0] rx_z,
    output logic [63:0] tx_x,
    output logic [63:0] tx_y,
    output logic [63:0] tx_z,
    output logic        out_valid,
    output logic [63:0] out_word
);
    beat_t beats [NUM_DIRS+1];
    word_t rx_arr [NUM_DIRS];
    word_t tx_arr [NUM_DIRS];

    // Entry beat: masks travel with their word so each stage sees its own.
    always_comb begin
        beats[0].valid            = in_valid;
        beats[0].data             = in_word;
        beats[0].mask[int'(DIR_X)] = mask_x;
        beats[0].mask[int'(DIR_Y)] = mask_y;
        beats[0].mask[int'(DIR_Z)] = mask_z;
    end

    assign rx_arr[int'(DIR_X)] = rx_x;
    assign rx_arr[int'(DIR_Y)] = rx_y;
    assign rx_arr[int'(DIR_Z)] = rx_z;

    // One registered stage per direction, x then y then z.
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        wrap_stage #(.DIR_IDX(d)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_beat  (beats[d]),
            .rx_bits  (rx_arr[d]),
            .tx_bits  (tx_arr[d]),
            .out_beat (beats[d+1])
        );
    end

    assign tx_x      = tx_arr[int'(DIR_X)];
    assign tx_y      = tx_arr[int'(DIR_Y)];
    assign tx_z      = tx_arr[int'(DIR_Z)];
    assign out_valid = beats[NUM_DIRS].valid;
    assign out_word  = beats[NUM_DIRS].data;
endmodule

// File: rtl/mesh_wrap_subst_chk.sv
module mesh_wrap_subst_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_word,
    input logic [63:0] mask_x,
    input logic [63:0] mask_y,
    input logic [63:0] mask_z,
    input logic [63:0] rx_x,
    input logic [63:0] rx_y,
    input logic [63:0] rx_z,
    input logic [63:0] tx_x,
    input logic [63:0] tx_y,
    input logic [63:0] tx_z,
    input logic        out_valid,
    input logic [63:0] out_word
);
    // Cycles since reset, saturating; guards every look into the past.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_tx_x_in_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_x & ~mask_x) == 64'd0);

    p_tx_y_in_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0) |-> ((tx_y & ~$past(mask_y)) == 64'd0));

    p_subst_z_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid) |->
        ((out_word & $past(mask_z, 3)) == ($past(rx_z, 1) & $past(mask_z, 3))));

    p_keep_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid) |->
        ((out_word & ~($past(mask_x, 3) | $past(mask_y, 3) | $past(mask_z, 3))) ==
         ($past(in_word, 3) & ~($past(mask_x, 3) | $past(mask_y, 3) | $past(mask_z, 3)))));

    p_idle_tx_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (tx_x == 64'd0));

    p_idle_out_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_word == 64'd0));

    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && tx_y == 64'd0 && tx_z == 64'd0));
endmodule

bind mesh_wrap_subst mesh_wrap_subst_chk i_chk (.*);

// File: tb/test_mesh_wrap_subst.sv
module test_mesh_wrap_subst;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 6;

    localparam logic [63:0] V_WORD [N_VEC] = '{
        64'hA5A5_A5A5_A5A5_A5A5, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
        64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0001};
    localparam logic [63:0] V_MX [N_VEC] = '{
        64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_000F,
        64'hFF00_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000};
    localparam logic [63:0] V_MY [N_VEC] = '{
        64'h0000_0000_0000_0000, 64'h00FF_00FF_00FF_00FF, 64'h0000_0000_0000_00FF,
        64'hF000_0000_0000_000F, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001};
    localparam logic [63:0] V_MZ [N_VEC] = '{
        64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0F00,
        64'hC000_0000_0000_0003, 64'h0000_FFFF_0000_0000, 64'h0000_0000_0000_0000};
    localparam logic [63:0] V_RX [N_VEC] = '{
        64'h1111_1111_1111_1111, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005,
        64'h1234_5678_9ABC_DEF0, 64'h5555_5555_5555_5555, 64'h0000_0000_0000_0000};
    localparam logic [63:0] V_RY [N_VEC] = '{
        64'h2222_2222_2222_2222, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0030,
        64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0000};
    localparam logic [63:0] V_RZ [N_VEC] = '{
        64'h3333_3333_3333_3333, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0000_0000_0000_0A00,
        64'h0000_0000_0000_0000, 64'h0000_1234_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_word, mask_x, mask_y, mask_z, rx_x, rx_y, rx_z;
    logic [63:0] tx_x, tx_y, tx_z, out_word;
    logic        out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_wrap_subst i_mesh_wrap_subst (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .mask_x(mask_x), .mask_y(mask_y), .mask_z(mask_z),
        .rx_x(rx_x), .rx_y(rx_y), .rx_z(rx_z),
        .tx_x(tx_x), .tx_y(tx_y), .tx_z(tx_z),
        .out_valid(out_valid), .out_word(out_word));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mrg(logic [63:0] w, logic [63:0] n, logic [63:0] m);
        return (w & ~m) | (n & m);
    endfunction

    // Expected word after each direction, computed from the requirements.
    function automatic logic [63:0] after_x(int i);
        return mrg(V_WORD[i], V_RX[i], V_MX[i]);
    endfunction
    function automatic logic [63:0] after_y(int i);
        return mrg(after_x(i), V_RY[i], V_MY[i]);
    endfunction
    function automatic logic [63:0] after_z(int i);
        return mrg(after_y(i), V_RZ[i], V_MZ[i]);
    endfunction

    task automatic idle_inputs();
        in_valid = 1'b0; in_word = '0; mask_x = '0; mask_y = '0; mask_z = '0;
        rx_x = '0; rx_y = '0; rx_z = '0;
    endtask

    // Waits for an edge, drives just after it, samples mid-cycle.
    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        step(); step();
        // R7: reset state
        #(CLK_PERIOD/4);
        chk("R7 out_valid in reset", {63'd0, out_valid}, 64'd0);
        chk("R7 out_word in reset", out_word, 64'd0);
        chk("R7 tx_x in reset", tx_x, 64'd0);
        rst = 1'b0;
        step(); step(); step();
        #(CLK_PERIOD/4);
        chk("R7 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R7 tx_y after reset", tx_y, 64'd0);
        chk("R7 tx_z after reset", tx_z, 64'd0);

        // Table walk: one word per cycle (R8), all stages checked each cycle.
        for (int k = 0; k < N_VEC + 3; k++) begin
            int jy, jz, jo;
            step();
            jy = k - 1; jz = k - 2; jo = k - 3;
            in_valid = (k < N_VEC);
            in_word  = (k < N_VEC) ? V_WORD[k] : '0;
            mask_x   = (k < N_VEC) ? V_MX[k] : '0;
            mask_y   = (k < N_VEC) ? V_MY[k] : '0;
            mask_z   = (k < N_VEC) ? V_MZ[k] : '0;
            rx_x     = (k < N_VEC) ? V_RX[k] : '0;
            rx_y     = (jy >= 0 && jy < N_VEC) ? V_RY[jy] : '0;
            rx_z     = (jz >= 0 && jz < N_VEC) ? V_RZ[jz] : '0;
            #(CLK_PERIOD/4);
            chk("R2 tx_x", tx_x, (k < N_VEC) ? (V_WORD[k] & V_MX[k]) : 64'd0);
            chk("R4 tx_y after x", tx_y,
                (jy >= 0 && jy < N_VEC) ? (after_x(jy) & V_MY[jy]) : 64'd0);
            chk("R4 tx_z after y", tx_z,
                (jz >= 0 && jz < N_VEC) ? (after_y(jz) & V_MZ[jz]) : 64'd0);
            chk("R1 out_valid", {63'd0, out_valid}, {63'd0, (jo >= 0 && jo < N_VEC)});
            chk("R3 out_word", out_word, (jo >= 0 && jo < N_VEC) ? after_z(jo) : 64'd0);
        end

        // R6: non-valid word with busy data, masks and links.
        step();
        idle_inputs();
        in_word = '1; mask_x = '1; mask_y = '1; mask_z = '1;
        rx_x = '1; rx_y = '1; rx_z = '1;
        #(CLK_PERIOD/4);
        chk("R6 tx_x idle", tx_x, 64'd0);
        step(); #(CLK_PERIOD/4);
        chk("R6 tx_y idle", tx_y, 64'd0);
        step(); #(CLK_PERIOD/4);
        chk("R6 tx_z idle", tx_z, 64'd0);
        step(); #(CLK_PERIOD/4);
        chk("R6 out_valid idle", {63'd0, out_valid}, 64'd0);
        chk("R6 out_word idle", out_word, 64'd0);

        // R5: all masks zero, links all ones -> word passes unchanged.
        step();
        idle_inputs();
        in_valid = 1'b1; in_word = 64'h5A5A_0F0F_3C3C_9696;
        rx_x = '1; rx_y = '1; rx_z = '1;
        step(); in_valid = 1'b0; in_word = '0;
        step(); step(); #(CLK_PERIOD/4);
        chk("R5 zero masks pass", out_word, 64'h5A5A_0F0F_3C3C_9696);
        chk("R5 out_valid", {63'd0, out_valid}, 64'd1);

        // R3: all masks ones -> the z link wins every bit.
        step();
        idle_inputs();
        in_valid = 1'b1; in_word = 64'hFFFF_FFFF_0000_0000;
        mask_x = '1; mask_y = '1; mask_z = '1; rx_x = 64'h1;
        #(CLK_PERIOD/4);
        chk("R2 tx_x full mask", tx_x, 64'hFFFF_FFFF_0000_0000);
        step(); idle_inputs(); rx_y = 64'h2;
        #(CLK_PERIOD/4);
        chk("R4 tx_y full mask", tx_y, 64'h1);
        step(); idle_inputs(); rx_z = 64'h0BAD_F00D_0000_1234;
        #(CLK_PERIOD/4);
        chk("R4 tx_z full mask", tx_z, 64'h2);
        step(); idle_inputs(); #(CLK_PERIOD/4);
        chk("R3 full mask takes z link", out_word, 64'h0BAD_F00D_0000_1234);

        // R7: reset in the middle of a run.
        step();
        in_valid = 1'b1; in_word = 64'h7777_7777_7777_7777; mask_y = '1;
        step();
        rst = 1'b1;
        step(); #(CLK_PERIOD/4);
        chk("R7 mid-run tx_y", tx_y, 64'd0);
        step();
        idle_inputs(); rst = 1'b0;
        #(CLK_PERIOD/4);
        chk("R7 mid-run out_valid", {63'd0, out_valid}, 64'd0);
        chk("R7 mid-run out_word", out_word, 64'd0);
        step(); step(); #(CLK_PERIOD/4);
        chk("R7 no leftover word", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule